// File: doc/BRIEF.md
# Banked Subarray Byte Memory

This block is a synthesizable model of a byte-wide static memory organised as eight one-bit-wide subarrays. Each subarray holds one bit position of every stored byte. A flat address is split in two. The upper field is decoded once into a one-hot row select, and that select is shared by all eight subarrays. The lower field drives a column multiplexer inside each subarray. A read captures the full selected row in every subarray. Each column multiplexer then picks one bit from its row, and the eight picked bits make up the output byte.

The row and column widths are parameters. The defaults give a small instance. Setting `ROW_BITS=12` and `COL_BITS=10` gives a 22-bit address space of 4M bytes, where each subarray is 4096 rows by 1024 columns.

The port is synchronous. Writes are qualified by chip enable together with write enable. Reads are qualified by chip enable together with output enable and return data one clock later. When no read was accepted on the previous edge, the output is held at zero and the valid flag is low.

Top module: `sram_banked_top`

## Requirements
- R1: The address `addr` is split into a row field in bits [ROW_BITS+COL_BITS-1:COL_BITS] and a column field in bits [COL_BITS-1:0]. Every distinct address stores its own byte.
- R2: Bit i of `din` is stored in subarray i and returned on bit i of `dout`. Every data bit is stored and returned independently of the other bits.
- R3: A write happens only on a rising edge where `ce` and `we` are both 1. With `ce` at 0, `we` leaves the contents unchanged.
- R4: A read requested on a rising edge (`ce` and `oe` both 1) presents the stored byte on `dout` with `dvalid` at 1 right after that edge, and holds it until the next edge.
- R5: After an edge where `ce` and `oe` were not both 1, `dout` is 8'h00 and `dvalid` is 0.
- R6: When a read and a write target the same address on the same edge, the read returns the byte stored before the write. A later read returns the new byte.
- R7: While `rst_n` is low, `dvalid` is 0 and `dout` is 8'h00.
- R8: Addresses that share a row but differ in column do not disturb each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Chip enable |
| oe | input | 1 | Output (read) enable |
| we | input | 1 | Write enable |
| addr | input | ROW_BITS+COL_BITS | Flat byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when idle |
| dvalid | output | 1 | High when `dout` carries read data |

## Verification
The bench fills every address with a distinct pattern and reads it back. A swapped row/column split or a misrouted subarray would show up as aliased or bit-shuffled bytes. Walking-one bytes at a single address expose any data bit that is stuck or shared between subarrays. A write with `we` high and `ce` low, followed by a read, would reveal a write gate that ignores chip enable. A read paired with a write to the same address must return the old byte, so a design that reads after writing would return the new value one access too early. Column neighbours in one row are rewritten and read back to catch a write that clobbers the whole row.

// File: rtl/sram_bank_pkg.sv
package sram_bank_pkg;
    // Number of bit lanes, one subarray per lane.
    localparam int unsigned LANES = 8;

    typedef logic [LANES-1:0] byte_t;
endpackage

// File: rtl/bank_row_decode.sv
module bank_row_decode #(
    parameter int unsigned ROW_BITS = 4
) (
    input  logic [ROW_BITS-1:0]      row,
    output logic [(1<<ROW_BITS)-1:0] row_sel
);
    localparam int unsigned ROWS = 1 << ROW_BITS;

    // One comparator per row line, shared by every subarray.
    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign row_sel[r] = (row == ROW_BITS'(r));
    end
endmodule

// File: rtl/bank_col_mux.sv
module bank_col_mux #(
    parameter int unsigned COL_BITS = 3
) (
    input  logic [(1<<COL_BITS)-1:0] row_bits,
    input  logic [COL_BITS-1:0]      col,
    output logic                     bit_o
);
    assign bit_o = row_bits[col];
endmodule

// File: rtl/bank_subarray.sv
module bank_subarray #(
    parameter int unsigned ROW_BITS = 4,
    parameter int unsigned COL_BITS = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [(1<<ROW_BITS)-1:0] row_sel,
    input  logic [COL_BITS-1:0]      col,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic                     wbit,
    output logic                     rbit
);
    localparam int unsigned ROWS = 1 << ROW_BITS;
    localparam int unsigned COLS = 1 << COL_BITS;

    typedef struct packed {
        logic [COLS-1:0]     rd_row;
        logic [COL_BITS-1:0] col;
    } rd_state_t;

    rd_state_t       st_d, st_q;
    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_rd;

    // Wired-OR of the selected row, driven by the shared one-hot decode.
    always_comb begin
        row_rd = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (row_sel[r]) row_rd = row_rd | cells[r];
        end
        st_d = st_q;
        if (rd_en) begin
            st_d.rd_row = row_rd;
            st_d.col    = col;
        end
    end

    // Row latch captures pre-write contents, so a colliding read sees old data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en && row_sel[r]) cells[r][col] <= wbit;
        end
    end

    bank_col_mux #(.COL_BITS(COL_BITS)) col_mux_i (
        .row_bits (st_q.rd_row),
        .col      (st_q.col),
        .bit_o    (rbit)
    );

    // The shared decoder must select exactly one row for any access.
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) |-> $onehot(row_sel));
endmodule

// File: rtl/sram_banked_top.sv
module sram_banked_top #(
    parameter int unsigned ROW_BITS  = 4,
    parameter int unsigned COL_BITS  = 3,
    parameter int unsigned ADDR_BITS = ROW_BITS + COL_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 oe,
    input  logic                 we,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [7:0]           din,
    output logic [7:0]           dout,
    output logic                 dvalid
);
    import sram_bank_pkg::*;

    localparam int unsigned ROWS = 1 << ROW_BITS;

    typedef struct packed {
        logic vld;
    } out_state_t;

    out_state_t          st_d, st_q;
    logic [ROW_BITS-1:0] row_f;
    logic [COL_BITS-1:0] col_f;
    logic [ROWS-1:0]     row_sel;
    logic                rd_go, wr_go;
    byte_t               lane_bits;

    assign row_f = addr[ADDR_BITS-1:COL_BITS];
    assign col_f = addr[COL_BITS-1:0];
    assign rd_go = ce && oe;
    assign wr_go = ce && we;

    bank_row_decode #(.ROW_BITS(ROW_BITS)) row_dec_i (
        .row     (row_f),
        .row_sel (row_sel)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        bank_subarray #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) sub_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .row_sel (row_sel),
            .col     (col_f),
            .wr_en   (wr_go),
            .rd_en   (rd_go),
            .wbit    (din[i]),
            .rbit    (lane_bits[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = rd_go;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dvalid = st_q.vld;
    assign dout   = st_q.vld ? lane_bits : 8'h00;

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && oe) |=> dvalid);

    assert_idle_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && oe) |=> (!dvalid && dout == 8'h00));

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |-> (!dvalid && dout == 8'h00));
endmodule

// File: tb/sram_banked_top_tb_top.sv
module sram_banked_top_tb_top;
    localparam int unsigned ROW_BITS  = 3;
    localparam int unsigned COL_BITS  = 2;
    localparam int unsigned ADDR_BITS = ROW_BITS + COL_BITS;
    localparam int unsigned NADDR     = 1 << ADDR_BITS;
    localparam time         PERIOD    = 10ns;

    typedef struct {
        logic       v;
        logic [7:0] d;
        string      tag;
    } exp_t;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 ce = 1'b0, oe = 1'b0, we = 1'b0;
    logic [ADDR_BITS-1:0] addr = '0;
    logic [7:0]           din = '0;
    logic [7:0]           dout;
    logic                 dvalid;

    logic [7:0] ref_mem [NADDR];
    exp_t       sb_q [$];
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    sram_banked_top #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS)) dut_i (
        .clk, .rst_n, .ce, .oe, .we, .addr, .din, .dout, .dvalid
    );

    always #(PERIOD/2) clk = ~clk;

    // Driver: one access per cycle, expected result from the bench model.
    task automatic drive(input logic c, input logic o, input logic w,
                         input logic [ADDR_BITS-1:0] a, input logic [7:0] d,
                         input string tag);
        exp_t e;
        @(negedge clk);
        ce = c; oe = o; we = w; addr = a; din = d;
        e.v   = c && o;
        e.d   = (c && o) ? ref_mem[a] : 8'h00;
        e.tag = tag;
        if (c && w) ref_mem[a] = d;
        sb_q.push_back(e);
    endtask

    // Monitor: compares one output per cycle, a quarter period after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(PERIOD/4);
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (dvalid !== e.v || dout !== e.d) begin
                    errors++;
                    $display("FAIL %s: dvalid=%0b dout=%02h expected dvalid=%0b dout=%02h",
                             e.tag, dvalid, dout, e.v, e.d);
                end
            end
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NADDR; a++) ref_mem[a] = 8'h00;
        repeat (3) @(negedge clk);
        checks++;   // R7: quiet outputs during reset
        if (dvalid !== 1'b0 || dout !== 8'h00) begin
            errors++;
            $display("FAIL R7: dvalid=%0b dout=%02h expected dvalid=0 dout=00", dvalid, dout);
        end
        rst_n = 1'b1;

        // R1 / R5: fill every address, no read requested so output idle.
        for (int a = 0; a < NADDR; a++)
            drive(1'b1, 1'b0, 1'b1, ADDR_BITS'(a), 8'(a * 37 + 5), "R5");
        // R1 / R2 / R4: read every address back.
        for (int a = 0; a < NADDR; a++)
            drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(a), 8'h00, "R1");

        // R3: write enable without chip enable must not store.
        drive(1'b0, 1'b0, 1'b1, ADDR_BITS'(3), 8'hAA, "R3");
        drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(3), 8'h00, "R3");
        // R5: output enable without chip enable gives idle output.
        drive(1'b0, 1'b1, 1'b0, ADDR_BITS'(3), 8'h00, "R5");

        // R6: colliding read and write return old data, then new data.
        drive(1'b1, 1'b1, 1'b1, ADDR_BITS'(9), 8'h5C, "R6");
        drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(9), 8'h00, "R6");

        // R2: walking one and walking zero on a single address.
        for (int i = 0; i < 8; i++) begin
            drive(1'b1, 1'b0, 1'b1, ADDR_BITS'(5), 8'(1 << i), "R2");
            drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(5), 8'h00, "R2");
            drive(1'b1, 1'b0, 1'b1, ADDR_BITS'(5), ~8'(1 << i), "R2");
            drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(5), 8'h00, "R2");
        end

        // R8: rewrite one column of a row, then read all columns of that row.
        drive(1'b1, 1'b0, 1'b1, ADDR_BITS'(13), 8'hF0, "R8");
        for (int c = 0; c < (1 << COL_BITS); c++)
            drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(12 + c), 8'h00, "R8");

        // R4: back-to-back reads to different rows.
        drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(0), 8'h00, "R4");
        drive(1'b1, 1'b1, 1'b0, ADDR_BITS'(NADDR - 1), 8'h00, "R4");
        drive(1'b0, 1'b0, 1'b0, ADDR_BITS'(0), 8'h00, "R5");

        wait (sb_q.size() == 0);
        #(PERIOD);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule